// File: doc/BRIEF.md
# Paper Tape Punch Command Controller

This block is the punch half of a paper tape controller attached to a 12-bit processor's I/O transfer bus. Each command cycle carries a three-bit function code and the accumulator. The block decodes the code combinationally, loads an 8-bit punch buffer from the accumulator's low byte, and times a punch cycle whose length comes from a programmable wait value. It keeps a done flag, a punch interrupt enable and an interrupt request, and it answers the skip test.

When a punch cycle ends, the buffered byte is presented for one clock on an output strobe, the done flag is set and a position counter advances. An `attached` input tells the block whether a medium is present. Without one, the strobe is suppressed and the position holds, but done is still set so software never stalls. Function codes with no defined meaning raise an illegal-command output. The accumulator always passes through unchanged.

Top module: `tape_punch_ctl`

## Requirements
- R1: Code 0 drives `rdr_ien_clr` high in the same cycle and clears the punch interrupt enable at the next clock edge.
- R2: Code 1 drives `skip` high in the same cycle exactly when the done flag is set; no other code raises `skip`.
- R3: Code 2 clears the done flag at the next edge and leaves the punch buffer, the active cycle and the position unchanged.
- R4: Code 4 loads `acc_in[7:0]` into the punch buffer (visible on `punch_byte`) and starts a punch cycle, leaving the done flag unchanged.
- R5: Code 6 clears the done flag and performs the same load and start as code 4.
- R6: A cycle started with wait value W at edge t ends at edge t+W+1: done is set there and, with `attached` high, `punch_strobe` is high for exactly the following clock cycle.
- R7: When `attached` is low at the edge where a cycle ends, `punch_strobe` stays low and `position` does not change, but done is set; otherwise `position` advances by one with each strobe and at no other time.
- R8: Codes 3, 5 and 7 drive `illegal` high in the same cycle; `acc_out` equals `acc_in` for every code.
- R9: Synchronous reset clears the punch buffer, the done flag, the position and any active cycle, and sets the punch interrupt enable.
- R10: `irq` is high exactly when the done flag and the punch interrupt enable are both set.
- R11: A code 4 or 6 issued while a cycle is active restarts the timer from the current wait value with the new byte; the old cycle produces no strobe.
- R12: `ien_set` high sets the punch interrupt enable at the next edge, and takes priority over a code 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iot_valid | input | 1 | A command for this device is on the bus this cycle |
| iot_code | input | 3 | Function code (low three bits of the instruction) |
| acc_in | input | 12 | Accumulator value from the processor |
| wait_len | input | 24 | Punch cycle length in clocks, minus one |
| attached | input | 1 | A medium is present to receive bytes |
| ien_set | input | 1 | Sets the punch interrupt enable (driven by the reader's enable command) |
| acc_out | output | 12 | Accumulator returned to the processor |
| skip | output | 1 | Skip condition for the flag test |
| illegal | output | 1 | Undefined function code seen |
| rdr_ien_clr | output | 1 | Request to clear the reader's interrupt enable |
| punch_byte | output | 8 | Contents of the punch buffer |
| punch_strobe | output | 1 | One-clock pulse marking an emitted byte |
| done | output | 1 | Punch done flag |
| pun_ien | output | 1 | Punch interrupt enable |
| irq | output | 1 | Punch interrupt request |
| position | output | 16 | Count of bytes emitted |

## Verification
The bench attacks the collisions: a reload in the middle of a running cycle, which a design that fails to restart would answer with an early strobe carrying the stale byte, and a done-clear arriving while a cycle is in flight, which a wrong design would let cancel the cycle or the load. It runs a zero wait value to catch an off-by-one in the timer, which would move the strobe by a clock, and detaches the medium at cycle end, where a wrong design either leaves done clear or still counts position. It also issues the enable clear and the enable set together, where the wrong priority leaves the interrupt masked.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
    localparam int ACC_W  = 12;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        OP_IEN_CLR = 3'd0,
        OP_SKIP    = 3'd1,
        OP_CLR     = 3'd2,
        OP_BAD3    = 3'd3,
        OP_LOAD    = 3'd4,
        OP_BAD5    = 3'd5,
        OP_CLR_LD  = 3'd6,
        OP_BAD7    = 3'd7
    } op_e;

    typedef struct packed {
        logic ien_clr;
        logic test;
        logic flag_clr;
        logic load;
        logic bad;
    } cmd_t;

    function automatic cmd_t decode_op(input logic valid, input op_e op);
        cmd_t c;
        c = '0;
        if (valid) begin
            unique case (op)
                OP_IEN_CLR: c.ien_clr  = 1'b1;
                OP_SKIP:    c.test     = 1'b1;
                OP_CLR:     c.flag_clr = 1'b1;
                OP_LOAD:    c.load     = 1'b1;
                OP_CLR_LD: begin
                    c.flag_clr = 1'b1;
                    c.load     = 1'b1;
                end
                default:    c.bad      = 1'b1;
            endcase
        end
        return c;
    endfunction
endpackage

// File: rtl/tpp_decoder.sv
module tpp_decoder
    import tpp_pkg::*;
(
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    output cmd_t              cmd
);
    always_comb cmd = decode_op(valid, op_e'(code));
endmodule

// File: rtl/tpp_cycle_timer.sv
module tpp_cycle_timer #(
    parameter int WAIT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_len,
    output logic              busy,
    output logic              finish
);
    logic [WAIT_W-1:0] remain;

    assign finish = busy && (remain == '0) && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= wait_len;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/tpp_flags.sv
module tpp_flags (
    input  logic clk,
    input  logic rst,
    input  logic flag_clr,
    input  logic flag_set,
    input  logic ien_clr,
    input  logic ien_set,
    output logic done,
    output logic ien
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            ien  <= 1'b1;
        end else begin
            done <= (done && !flag_clr) || flag_set;
            if (ien_set)      ien <= 1'b1;
            else if (ien_clr) ien <= 1'b0;
        end
    end
endmodule

// File: rtl/tape_punch_ctl.sv
module tape_punch_ctl
    import tpp_pkg::*;
#(
    parameter int WAIT_W = 24,
    parameter int POS_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iot_valid,
    input  logic [2:0]        iot_code,
    input  logic [11:0]       acc_in,
    input  logic [WAIT_W-1:0] wait_len,
    input  logic              attached,
    input  logic              ien_set,
    output logic [11:0]       acc_out,
    output logic              skip,
    output logic              illegal,
    output logic              rdr_ien_clr,
    output logic [7:0]        punch_byte,
    output logic              punch_strobe,
    output logic              done,
    output logic              pun_ien,
    output logic              irq,
    output logic [POS_W-1:0]  position
);
    cmd_t              cmd;
    logic              busy;
    logic              finish;
    logic [BYTE_W-1:0] buf_q;

    tpp_decoder u_dec (
        .valid (iot_valid),
        .code  (iot_code),
        .cmd   (cmd)
    );

    tpp_cycle_timer #(.WAIT_W(WAIT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .start    (cmd.load),
        .wait_len (wait_len),
        .busy     (busy),
        .finish   (finish)
    );

    tpp_flags u_flg (
        .clk      (clk),
        .rst      (rst),
        .flag_clr (cmd.flag_clr),
        .flag_set (finish),
        .ien_clr  (cmd.ien_clr),
        .ien_set  (ien_set),
        .done     (done),
        .ien      (pun_ien)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q        <= '0;
            punch_strobe <= 1'b0;
            position     <= '0;
        end else begin
            if (cmd.load) buf_q <= acc_in[BYTE_W-1:0];
            punch_strobe <= finish && attached;
            if (finish && attached) position <= position + 1'b1;
        end
    end

    assign acc_out     = acc_in;
    assign skip        = cmd.test && done;
    assign illegal     = cmd.bad;
    assign rdr_ien_clr = cmd.ien_clr;
    assign punch_byte  = buf_q;
    assign irq         = done && pun_ien;
endmodule

// File: rtl/tpp_checker.sv
module tpp_checker #(
    parameter int POS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             iot_valid,
    input logic [2:0]       iot_code,
    input logic             attached,
    input logic             ien_set,
    input logic             skip,
    input logic             illegal,
    input logic             punch_strobe,
    input logic             done,
    input logic             pun_ien,
    input logic             irq,
    input logic [POS_W-1:0] position
);
    AST_SKIP_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        skip |-> (done && iot_valid && iot_code == 3'd1)); // R2
    AST_ILLEGAL_CODES: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (iot_valid && iot_code[0] && iot_code != 3'd1)); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pun_ien && done)); // R10
    AST_STROBE_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        punch_strobe |-> done); // R6
    AST_STROBE_NEEDS_MEDIUM: assert property (@(posedge clk) disable iff (rst)
        (punch_strobe && !$past(rst)) |-> $past(attached)); // R7
    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && position != $past(position)) |->
            (punch_strobe && position == $past(position) + 1'b1)); // R7
    AST_IEN_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(iot_valid && iot_code == 3'd0) && !$past(ien_set))
            |-> !pun_ien); // R1
    AST_IEN_SET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ien_set)) |-> pun_ien); // R12
endmodule

bind tape_punch_ctl tpp_checker #(.POS_W(POS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .iot_valid    (iot_valid),
    .iot_code     (iot_code),
    .attached     (attached),
    .ien_set      (ien_set),
    .skip         (skip),
    .illegal      (illegal),
    .punch_strobe (punch_strobe),
    .done         (done),
    .pun_ien      (pun_ien),
    .irq          (irq),
    .position     (position)
);

// File: tb/tape_punch_ctl_test.sv
module tape_punch_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iot_valid = 1'b0;
    logic [2:0]  iot_code = 3'd0;
    logic [11:0] acc_in = 12'd0;
    logic [23:0] wait_len = 24'd0;
    logic        attached = 1'b1;
    logic        ien_set = 1'b0;
    logic [11:0] acc_out;
    logic        skip, illegal, rdr_ien_clr, punch_strobe, done, pun_ien, irq;
    logic [7:0]  punch_byte;
    logic [15:0] position;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // behavioural reference state
    bit m_done, m_en, m_busy, m_strobe;
    int m_cnt, m_buf, m_pos;

    always #(CLK_PERIOD/2) clk = ~clk;

    tape_punch_ctl uut (
        .clk(clk), .rst(rst), .iot_valid(iot_valid), .iot_code(iot_code),
        .acc_in(acc_in), .wait_len(wait_len), .attached(attached),
        .ien_set(ien_set), .acc_out(acc_out), .skip(skip), .illegal(illegal),
        .rdr_ien_clr(rdr_ien_clr), .punch_byte(punch_byte),
        .punch_strobe(punch_strobe), .done(done), .pun_ien(pun_ien),
        .irq(irq), .position(position)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_code(input int c);
        return iot_valid && iot_code == c[2:0];
    endfunction

    // apply inputs, compare, advance one clock, update model
    task automatic step(input bit v, input int code, input int acc);
        bit fin, ld, clr;
        iot_valid = v; iot_code = code[2:0]; acc_in = acc[11:0];
        #1;
        if (!rst) begin
            chk("R8",  "acc_out", acc_out, acc);
            chk("R8",  "illegal", illegal, (is_code(3) || is_code(5) || is_code(7)) ? 1 : 0);
            chk("R2",  "skip", skip, (is_code(1) && m_done) ? 1 : 0);
            chk("R1",  "rdr_ien_clr", rdr_ien_clr, is_code(0) ? 1 : 0);
            chk("R6",  "done", done, m_done);
            chk("R12", "pun_ien", pun_ien, m_en);
            chk("R10", "irq", irq, (m_done && m_en) ? 1 : 0);
            chk("R6",  "strobe", punch_strobe, m_strobe);
            chk("R4",  "punch_byte", punch_byte, m_buf);
            chk("R7",  "position", position, m_pos);
        end
        @(posedge clk);
        if (rst) begin
            m_done = 0; m_en = 1; m_busy = 0; m_strobe = 0;
            m_cnt = 0; m_buf = 0; m_pos = 0;
        end else begin
            ld  = is_code(4) || is_code(6);
            clr = is_code(2) || is_code(6);
            fin = m_busy && m_cnt == 0 && !ld;
            m_done = (m_done && !clr) || fin;
            if (ien_set) m_en = 1;
            else if (is_code(0)) m_en = 0;
            m_strobe = fin && attached;
            if (fin && attached) m_pos = (m_pos + 1) % 65536;
            if (ld) begin
                m_busy = 1; m_cnt = int'(wait_len); m_buf = acc & 255;
            end else if (m_busy) begin
                if (m_cnt == 0) m_busy = 0; else m_cnt--;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 12'o1234);
    endtask

    initial begin
        fork
            begin
                while (cycles < 100000) begin @(posedge clk); cycles++; end
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        @(negedge clk);
        step(1'b0, 0, 0);
        step(1'b0, 0, 0);
        rst = 1'b0;
        // R9: reset state
        chk("R9", "reset done", done, 0);
        chk("R9", "reset enable", pun_ien, 1);
        chk("R9", "reset buffer", punch_byte, 0);
        chk("R9", "reset position", position, 0);
        idle(2);

        // R4 and R6: load with wait 3, attached
        wait_len = 24'd3;
        step(1'b1, 4, 12'o7245);
        chk("R4", "buffer loaded", punch_byte, 8'hA5);
        idle(3);
        chk("R6", "no early done", done, 0);
        idle(1);
        chk("R6", "done at end", done, 1);
        chk("R6", "strobe at end", punch_strobe, 1);
        step(1'b1, 1, 0);   // R2 skip test with done set
        idle(2);

        // R3: clear flag only, while a cycle is active
        step(1'b1, 4, 12'h03C);
        step(1'b1, 2, 12'hFFF);
        chk("R3", "flag cleared", done, 0);
        chk("R3", "buffer kept", punch_byte, 8'h3C);
        idle(5);
        chk("R3", "cycle survived clear", done, 1);

        // R5: code 6 clears and loads; wait 0 boundary
        wait_len = 24'd0;
        step(1'b1, 6, 12'h1E7);
        chk("R5", "flag cleared by code 6", done, 0);
        chk("R5", "buffer from code 6", punch_byte, 8'hE7);
        idle(1);
        chk("R6", "wait zero ends next edge", done, 1);
        chk("R6", "wait zero strobe", punch_strobe, 1);

        // R11: reload mid cycle
        wait_len = 24'd4;
        step(1'b1, 4, 12'h011);
        idle(2);
        step(1'b1, 4, 12'h022);
        idle(4);
        chk("R11", "no strobe from old cycle", punch_strobe, 0);
        idle(2);
        chk("R11", "new byte", punch_byte, 8'h22);

        // R7: detached medium
        attached = 1'b0;
        wait_len = 24'd1;
        step(1'b1, 6, 12'h055);
        idle(4);
        chk("R7", "done without medium", done, 1);
        attached = 1'b1;

        // R8 illegal codes, R1 / R12 enable control, R10
        step(1'b1, 3, 12'o4321);
        step(1'b1, 5, 12'o0017);
        step(1'b1, 7, 12'o7777);
        step(1'b1, 0, 0);
        chk("R1", "enable cleared", pun_ien, 0);
        chk("R10", "irq masked", irq, 0);
        ien_set = 1'b1;
        step(1'b1, 0, 0);
        ien_set = 1'b0;
        chk("R12", "set beats clear", pun_ien, 1);
        chk("R10", "irq restored", irq, 1);
        idle(2);

        // R9: reset cancels an active cycle
        wait_len = 24'd2;
        step(1'b1, 4, 12'h099);
        rst = 1'b1;
        step(1'b0, 0, 0);
        rst = 1'b0;
        idle(5);
        chk("R9", "cycle cancelled", done, 0);
        chk("R9", "buffer cleared", punch_byte, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule